// File: doc/BRIEF.md
# Headset Jack Plug-State Debouncer with Change Interrupt

This block sits behind the two comparator outputs that sense what is plugged into a headset jack. It brings the raw two-bit sense code into the clock domain, classifies it as no plug, headphone or headset, and publishes a new plug state only after the code has held still for a selectable debounce time counted in millisecond ticks. The time choices are 25, 50, 100 and 200 ms.

Each accepted state change sets a sticky change flag. When the interrupt enable is high, the flag pulls an active-low interrupt line low. The line stays low until the host reads status, which the host signals with a one-cycle read strobe. A change accepted in the same cycle as a read wins, so no event is lost.

Top module: `jack_plug_monitor`

## Requirements
- R1: While reset is held, and for two clock cycles after it is released, plug_state reads 2'b11, change_flag reads 0 and irq_n reads 1.
- R2: The debounce time in millisecond ticks is 25 for debounce select 2'b00, 50 for 2'b01, 100 for 2'b10 and 200 for 2'b11. The sense input passes through two synchronizer flops. After that, a new code updates plug_state on the tick that completes that many ticks of a stable code, and plug_state changes on no other edge.
- R3: Any change of the synchronized code while a count runs restarts the count from zero with the new code as the candidate.
- R4: A new debounce select value given while a count runs is not used until the count next restarts, or until the block is idle again.
- R5: The plug_state codes are 2'b11 for no plug, 2'b01 for headset and 2'b00 for headphone. The reserved sense code 2'b10 is classified as no plug, so plug_state never reads 2'b10.
- R6: Every accepted change of plug_state sets change_flag in the same cycle. The flag stays set until a status read.
- R7: A status_rd pulse clears change_flag on the next clock edge.
- R8: irq_n is registered. It is low exactly when, after the previous edge, change_flag is set and irq_enable was high at that edge.
- R9: If a change is accepted in the same cycle as status_rd, change_flag is set afterwards.
- R10: A code that returns to the current plug state before its debounce time completes leaves plug_state and change_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sense_raw | input | 2 | Raw jack comparator outputs, asynchronous |
| debounce_sel | input | 2 | Debounce time select |
| irq_enable | input | 1 | Allows the change flag to drive the interrupt |
| status_rd | input | 1 | One-cycle pulse when the host reads status |
| plug_state | output | 2 | Debounced plug state code |
| change_flag | output | 1 | Sticky flag for an accepted state change |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A count that is off by one, or a limit loaded at the wrong moment, moves the plug_state update by one or more tick periods. The every-cycle comparison against the reference model catches this on the first acceptance. A candidate register that fails to restart shows up as an early plug_state change during the bounce and hold-off scenarios. Flag or interrupt faults show on change_flag or irq_n within one cycle of an acceptance, a read, or an enable toggle.

// File: rtl/plug_pkg.sv
package plug_pkg;
  typedef enum logic [1:0] {
    PLUG_HEADPHONE = 2'b00,
    PLUG_HEADSET   = 2'b01,
    PLUG_RESERVED  = 2'b10,
    PLUG_NONE      = 2'b11
  } plug_code_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RST_VAL;
          else         stage_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RST_VAL;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/plug_classify.sv
module plug_classify
  import plug_pkg::*;
(
  input  logic [1:0] code_i,
  output logic [1:0] class_o
);
  always_comb begin
    unique case (code_i)
      2'b00:   class_o = PLUG_HEADPHONE;
      2'b01:   class_o = PLUG_HEADSET;
      default: class_o = PLUG_NONE;
    endcase
  end
endmodule

// File: rtl/debounce_timer.sv
module debounce_timer
  import plug_pkg::*;
#(
  parameter int BASE_TICKS = 25,
  localparam int MAX_TICKS = BASE_TICKS << 3,
  localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       class_i,
  output logic [1:0]       state_o,
  output logic             accept_o
);
  logic [1:0]       cand_q, cand_d;
  logic [1:0]       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             cand_en, state_en, cnt_en, lim_en;
  logic [CNT_W-1:0] lim_load;
  logic [CNT_W-1:0] cnt_inc;
  logic             moved, pending, done;

  assign lim_load = CNT_W'(BASE_TICKS) << sel_i;
  assign cnt_inc  = cnt_q + 1'b1;
  assign moved    = (class_i != cand_q);
  assign pending  = !moved && (cand_q != state_q);
  assign done     = pending && tick_i && (cnt_inc == lim_q);

  always_comb begin
    cand_d   = cand_q;
    state_d  = state_q;
    cnt_d    = cnt_q;
    lim_d    = lim_q;
    cand_en  = 1'b0;
    state_en = 1'b0;
    cnt_en   = 1'b0;
    lim_en   = 1'b0;
    if (moved) begin
      cand_d  = class_i;
      cand_en = 1'b1;
      cnt_d   = '0;
      cnt_en  = 1'b1;
      lim_d   = lim_load;
      lim_en  = 1'b1;
    end else if (pending) begin
      if (tick_i) begin
        cnt_en = 1'b1;
        if (done) begin
          state_d  = cand_q;
          state_en = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
    end else begin
      cnt_d  = '0;
      cnt_en = 1'b1;
      lim_d  = lim_load;
      lim_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= PLUG_NONE;
      state_q <= PLUG_NONE;
      cnt_q   <= '0;
      lim_q   <= CNT_W'(BASE_TICKS);
    end else begin
      if (cand_en)  cand_q  <= cand_d;
      if (state_en) state_q <= state_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (lim_en)   lim_q   <= lim_d;
    end
  end

  assign state_o  = state_q;
  assign accept_o = done;
endmodule

// File: rtl/change_irq.sv
module change_irq (
  input  logic clk,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic read_i,
  input  logic enable_i,
  output logic flag_o,
  output logic irq_no
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = accept_i | (flag_q & ~read_i);
    irq_d  = ~(flag_d & enable_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b1;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_no = irq_q;
endmodule

// File: rtl/jack_plug_monitor.sv
module jack_plug_monitor
  import plug_pkg::*;
#(
  parameter int BASE_TICKS  = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] sense_raw,
  input  logic [1:0] debounce_sel,
  input  logic       irq_enable,
  input  logic       status_rd,
  output logic [1:0] plug_state,
  output logic       change_flag,
  output logic       irq_n
);
  logic       rst_meta_q, rst_int_n;
  logic [1:0] sense_sync_w;
  logic [1:0] sense_class;
  logic       accept_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  sense_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .async_i(sense_raw),
    .sync_o (sense_sync_w)
  );

  plug_classify u_class (
    .code_i (sense_sync_w),
    .class_o(sense_class)
  );

  debounce_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .tick_i  (ms_tick),
    .sel_i   (debounce_sel),
    .class_i (sense_class),
    .state_o (plug_state),
    .accept_o(accept_evt)
  );

  change_irq u_irq (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .accept_i(accept_evt),
    .read_i  (status_rd),
    .enable_i(irq_enable),
    .flag_o  (change_flag),
    .irq_no  (irq_n)
  );
endmodule

// File: rtl/jack_plug_monitor_checks.sv
module jack_plug_monitor_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       irq_enable,
  input logic       status_rd,
  input logic [1:0] plug_state,
  input logic       change_flag,
  input logic       irq_n,
  input logic       accept_evt
);
  assert_state_on_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ms_tick) |-> $stable(plug_state));

  assert_no_reserved_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    plug_state != 2'b10);

  assert_change_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_state != $past(plug_state)) |-> change_flag);

  assert_flag_clears_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(change_flag) |-> $past(status_rd));

  assert_irq_tracks_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !(change_flag && $past(irq_enable)));

  assert_accept_wins_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> change_flag);
endmodule

bind jack_plug_monitor jack_plug_monitor_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .irq_enable (irq_enable),
  .status_rd  (status_rd),
  .plug_state (plug_state),
  .change_flag(change_flag),
  .irq_n      (irq_n),
  .accept_evt (accept_evt)
);

// File: tb/jack_plug_monitor_test.sv
module jack_plug_monitor_test;
  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic [1:0] sense_raw;
  logic [1:0] debounce_sel;
  logic       irq_enable;
  logic       status_rd;
  logic [1:0] plug_state;
  logic       change_flag;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit seen_flag;

  jack_plug_monitor uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sense_raw(sense_raw),
    .debounce_sel(debounce_sel), .irq_enable(irq_enable), .status_rd(status_rd),
    .plug_state(plug_state), .change_flag(change_flag), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int m_rs1, m_rs2, m_s1, m_s2, m_cand, m_state, m_cnt, m_lim, m_flag, m_irq;
  always @(posedge clk or negedge rst_n) begin
    int cls;
    int acc;
    if (!rst_n || !m_rs2) begin
      if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
      else begin m_rs2 = m_rs1; m_rs1 = 1; end
      m_s1 = 3; m_s2 = 3; m_cand = 3; m_state = 3;
      m_cnt = 0; m_lim = 25; m_flag = 0; m_irq = 1;
    end else begin
      cls = (m_s2 == 2) ? 3 : m_s2;
      acc = 0;
      if (cls != m_cand) begin
        m_cand = cls; m_cnt = 0; m_lim = 25 * (1 << debounce_sel);
      end else if (m_cand != m_state) begin
        if (ms_tick) begin
          if (m_cnt + 1 == m_lim) begin m_state = m_cand; acc = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end else begin
        m_cnt = 0; m_lim = 25 * (1 << debounce_sel);
      end
      m_flag = acc | (m_flag & !status_rd);
      m_irq  = !(m_flag && irq_enable);
      m_s2 = m_s1; m_s1 = sense_raw;
    end
  end

  // every-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 plug_state", plug_state, m_state);
      check("R6 change_flag", change_flag, m_flag);
      check("R8 irq_n", irq_n, m_irq);
    end
    if (status_rd && change_flag) seen_flag = 1'b1;
  end

  initial begin
    ms_tick = 1'b0;
    forever begin
      @(negedge clk);
      ms_tick = ~ms_tick;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_status;
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sense_raw = 2'b11; debounce_sel = 2'b00;
    irq_enable = 1'b1; status_rd = 1'b0;
    cyc(4);
    check("R1 state", plug_state, 3);
    check("R1 flag", change_flag, 0);
    check("R1 irq", irq_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state after release", plug_state, 3);
    cyc(4);

    // headset insert, 25 ticks
    sense_raw = 2'b01;
    cyc(40);
    check("R2 not yet", plug_state, 3);
    cyc(30);
    check("R2 headset", plug_state, 1);
    check("R6 flag", change_flag, 1);
    check("R8 irq low", irq_n, 0);
    read_status();
    @(negedge clk);
    check("R7 cleared", change_flag, 0);
    check("R7 irq high", irq_n, 1);

    // short removal glitch cancels
    sense_raw = 2'b11; cyc(20); sense_raw = 2'b01; cyc(80);
    check("R10 state kept", plug_state, 1);
    check("R10 no flag", change_flag, 0);

    // bouncing restarts count
    sense_raw = 2'b00;
    for (int i = 0; i < 4; i++) begin
      cyc(30); sense_raw = (i % 2 == 0) ? 2'b11 : 2'b00;
    end
    check("R3 still headset", plug_state, 1);
    cyc(45);
    check("R3 restarted count", plug_state, 1);
    cyc(30);
    check("R3 headphone accepted", plug_state, 0);
    read_status();

    // select change during count waits for restart
    debounce_sel = 2'b11;
    sense_raw = 2'b01;
    cyc(100);
    debounce_sel = 2'b00;
    cyc(100);
    check("R4 old limit held", plug_state, 0);
    cyc(220);
    check("R4 long limit used", plug_state, 1);
    read_status();

    // 50 and 100 tick selects
    debounce_sel = 2'b01; sense_raw = 2'b11;
    cyc(95);  check("R2 50 ticks pending", plug_state, 1);
    cyc(15);  check("R2 50 ticks done", plug_state, 3);
    read_status();
    debounce_sel = 2'b10; sense_raw = 2'b00;
    cyc(195); check("R2 100 ticks pending", plug_state, 3);
    cyc(15);  check("R2 100 ticks done", plug_state, 0);

    // interrupt gating
    irq_enable = 1'b0; cyc(2);
    check("R8 masked", irq_n, 1);
    check("R6 sticky", change_flag, 1);
    irq_enable = 1'b1; cyc(2);
    check("R8 unmasked", irq_n, 0);
    read_status();

    // reserved code reads as no plug
    debounce_sel = 2'b00; sense_raw = 2'b10;
    cyc(70);
    check("R5 reserved as none", plug_state, 3);
    read_status();

    // acceptance during a held read
    sense_raw = 2'b01; cyc(3);
    status_rd = 1'b1; cyc(2); seen_flag = 1'b0;
    cyc(70);
    check("R9 flag seen set", seen_flag, 1);
    status_rd = 1'b0; cyc(2);
    check("R9 state", plug_state, 1);
    check("R9 cleared by read", change_flag, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule